// File: doc/BRIEF.md
# Integer Operate ALU with Scaled-Add

This block is the purely combinational integer execution datapath of a 64-bit load/store processor. Each cycle it receives the first register operand, a second register operand, and an 8-bit literal together with a flag that picks the literal instead of the second register. A class select and a function code choose one result. The result is always 64 bits wide and goes straight to the register write port.

The arithmetic class covers addition and subtraction on the full 64 bits and on the low 32 bits. It also covers scaled forms that multiply the first operand by 4 or 8 before the add or subtract, which serve array-index address arithmetic. The 32-bit forms sign-extend their result to 64 bits. The logic class is one AND/OR/XOR unit with an optional inversion of the second operand, which gives six operations. The shift class provides left shift, logical right shift and arithmetic right shift, always on the full 64 bits. Arithmetic wraps silently: there is no overflow flag and no trap.

Top module: `int_op_alu`

## Requirements
- R1: When `use_lit` is 1 the second operand is `lit` zero-extended to 64 bits and `opb` is ignored. When `use_lit` is 0 the second operand is `opb`.
- R2: The arithmetic class is selected by `op_class` = 0. In it, `func[0]` = 1 selects subtract and 0 selects add, and `func[3]` = 0 selects quad width. At quad width with no scaling (`func[2:1]` = 00) the result is A+B or A−B modulo 2^64.
- R3: With `func[3]` = 1 (long width), the operation uses only the low 32 bits of each operand. The low 32 bits of the result are the 32-bit sum or difference modulo 2^32, and bits 63:32 are copies of bit 31.
- R4: `func[2:1]` = 01 multiplies A by 4 and `func[2:1]` = 10 multiplies A by 8 before the add or subtract, at both widths. `func[2:1]` = 11 gives a result of zero.
- R5: The logic class is selected by `op_class` = 1. `func[6:5]` picks the base operation: 00 AND, 01 OR, 10 XOR. `func[3]` = 1 inverts B before the base operation, which gives the codes 0x00, 0x20, 0x40, 0x08, 0x28 and 0x48. `func[6:5]` = 11 gives zero. The other function bits have no effect, and all 64 bits are processed.
- R6: The shift class is selected by `op_class` = 2. `func[1:0]` = 00 is a left shift and 01 is a logical right shift; both fill vacated bits with zero. The shift amount is B modulo 64, that is B[5:0].
- R7: In the shift class, `func[1:0]` = 10 is an arithmetic right shift that fills vacated bits with bit 63 of A. `func[1:0]` = 11 gives zero, and no shift has a 32-bit variant.
- R8: An `op_class` value of 3 or above gives a result of zero. At most one result path drives the output at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 64 | First register operand A |
| opb | input | 64 | Second register operand |
| lit | input | 8 | Unsigned literal for the second operand |
| use_lit | input | 1 | 1 selects the literal as B |
| op_class | input | 3 | Operation class: 0 arithmetic, 1 logic, 2 shift |
| func | input | 7 | Function code within the class |
| result | output | 64 | Result for the register write |

## Verification
The block holds no state, so any fault shows at `result` in the same cycle as the operands that trigger it. A wrong decode shows up in one of three ways: the output is driven by two paths mixed together, the output stays zero where a result is expected, or it is nonzero for a reserved code. A wrong scale or width path typically corrupts only the upper half of the result, or only operands with bit 31 set. For this reason the random operands are mixed with sign-boundary values, and literals are chosen so that shift amounts of 0 and 63 occur.

// File: rtl/int_op_alu_pkg.sv
package int_op_alu_pkg;
    localparam int CLASS_W = 3;
    localparam int FUNC_W  = 7;

    typedef enum logic [CLASS_W-1:0] {
        CLS_ARITH = 3'd0,
        CLS_LOGIC = 3'd1,
        CLS_SHIFT = 3'd2
    } alu_class_e;

    typedef enum logic [1:0] {
        LOG_AND = 2'b00,
        LOG_OR  = 2'b01,
        LOG_XOR = 2'b10
    } logic_base_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'b00,
        SH_RLOG  = 2'b01,
        SH_RARI  = 2'b10
    } shift_kind_e;

    typedef enum logic [1:0] {
        SC_ONE   = 2'b00,
        SC_FOUR  = 2'b01,
        SC_EIGHT = 2'b10
    } scale_e;

    typedef struct packed {
        logic arith;
        logic logic_op;
        logic shift;
    } path_sel_t;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
    parameter int XLEN  = 64,
    parameter int LIT_W = 8
) (
    input  logic [XLEN-1:0]  reg_b,
    input  logic [LIT_W-1:0] lit_b,
    input  logic             pick_lit,
    output logic [XLEN-1:0]  b_eff
);
    localparam int PAD_W = XLEN - LIT_W;

    always_comb begin
        if (pick_lit) begin
            b_eff = {{PAD_W{1'b0}}, lit_b};
        end else begin
            b_eff = reg_b;
        end
        if (pick_lit) begin
            AST_LIT_ZEXT: assert (b_eff[XLEN-1:LIT_W] == '0 && b_eff[LIT_W-1:0] == lit_b); // R1
        end
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import int_op_alu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int FUNC_W = 7
) (
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic [FUNC_W-1:0] fn,
    output logic [XLEN-1:0]   res
);
    localparam int HALF = XLEN / 2;

    logic            is_sub;
    logic            is_long;
    scale_e          scale;
    logic [XLEN-1:0] a_scaled_d;
    logic [XLEN-1:0] raw_d;

    always_comb begin
        is_sub  = fn[0];
        is_long = fn[3];
        scale   = scale_e'(fn[2:1]);
        case (scale)
            SC_FOUR:  a_scaled_d = a << 2;
            SC_EIGHT: a_scaled_d = a << 3;
            default:  a_scaled_d = a;
        endcase
        raw_d = is_sub ? (a_scaled_d - b) : (a_scaled_d + b);
        if (fn[2:1] == 2'b11) begin
            res = '0;
        end else if (is_long) begin
            res = {{HALF{raw_d[HALF-1]}}, raw_d[HALF-1:0]};
        end else begin
            res = raw_d;
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import int_op_alu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int FUNC_W = 7
) (
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic [FUNC_W-1:0] fn,
    output logic [XLEN-1:0]   res
);
    logic [XLEN-1:0] b_mod_d;
    logic_base_e     base;

    always_comb begin
        base    = logic_base_e'(fn[6:5]);
        b_mod_d = fn[3] ? ~b : b;
        case (base)
            LOG_AND: res = a & b_mod_d;
            LOG_OR:  res = a | b_mod_d;
            LOG_XOR: res = a ^ b_mod_d;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import int_op_alu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int FUNC_W = 7
) (
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic [FUNC_W-1:0] fn,
    output logic [XLEN-1:0]   res
);
    localparam int SHAMT_W = $clog2(XLEN);

    shift_kind_e        kind;
    logic               go_left;
    logic               fill;
    logic [SHAMT_W-1:0] amt;
    logic [XLEN-1:0]    a_rev;
    logic [XLEN-1:0]    stage_in;
    logic [XLEN-1:0]    stage [0:SHAMT_W];
    logic [XLEN-1:0]    out_rev;

    always_comb begin
        kind    = shift_kind_e'(fn[1:0]);
        go_left = (kind == SH_LEFT);
        fill    = (kind == SH_RARI) & a[XLEN-1];
        amt     = b[SHAMT_W-1:0];
    end

    genvar gi;
    generate
        for (gi = 0; gi < XLEN; gi++) begin : g_rev
            assign a_rev[gi]   = a[XLEN-1-gi];
            assign out_rev[gi] = stage[SHAMT_W][XLEN-1-gi];
        end
    endgenerate

    assign stage_in = go_left ? a_rev : a;
    assign stage[0] = stage_in;

    generate
        for (gi = 0; gi < SHAMT_W; gi++) begin : g_stage
            localparam int STEP = 1 << gi;
            assign stage[gi+1] = amt[gi]
                ? {{STEP{fill}}, stage[gi][XLEN-1:STEP]}
                : stage[gi];
        end
    endgenerate

    always_comb begin
        if (fn[1:0] == 2'b11) begin
            res = '0;
        end else if (go_left) begin
            res = out_rev;
        end else begin
            res = stage[SHAMT_W];
        end
    end
endmodule

// File: rtl/int_op_alu.sv
module int_op_alu
    import int_op_alu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LIT_W = 8
) (
    input  logic [XLEN-1:0]    opa,
    input  logic [XLEN-1:0]    opb,
    input  logic [LIT_W-1:0]   lit,
    input  logic               use_lit,
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNC_W-1:0]  func,
    output logic [XLEN-1:0]    result
);
    localparam int HALF    = XLEN / 2;
    localparam int SHAMT_W = $clog2(XLEN);

    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] arith_res;
    logic [XLEN-1:0] logic_res;
    logic [XLEN-1:0] shift_res;
    path_sel_t       sel_d;

    alu_operand_sel #(.XLEN(XLEN), .LIT_W(LIT_W)) u_bsel (
        .reg_b    (opb),
        .lit_b    (lit),
        .pick_lit (use_lit),
        .b_eff    (b_eff)
    );

    alu_arith #(.XLEN(XLEN), .FUNC_W(FUNC_W)) u_arith (
        .a   (opa),
        .b   (b_eff),
        .fn  (func),
        .res (arith_res)
    );

    alu_logic #(.XLEN(XLEN), .FUNC_W(FUNC_W)) u_logic (
        .a   (opa),
        .b   (b_eff),
        .fn  (func),
        .res (logic_res)
    );

    alu_shift #(.XLEN(XLEN), .FUNC_W(FUNC_W)) u_shift (
        .a   (opa),
        .b   (b_eff),
        .fn  (func),
        .res (shift_res)
    );

    always_comb begin
        sel_d          = '0;
        sel_d.arith    = (op_class == CLS_ARITH);
        sel_d.logic_op = (op_class == CLS_LOGIC);
        sel_d.shift    = (op_class == CLS_SHIFT);
        result = ({XLEN{sel_d.arith}}    & arith_res)
               | ({XLEN{sel_d.logic_op}} & logic_res)
               | ({XLEN{sel_d.shift}}    & shift_res);
    end

    always_comb begin
        AST_SEL_ONEHOT: assert ($onehot0(sel_d)); // R8
        if (op_class > 3'd2) begin
            AST_RESERVED_ZERO: assert (result == '0); // R8
        end
        if (op_class == CLS_ARITH && func[3] && func[2:1] != 2'b11) begin
            AST_LONG_EXT: assert (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}); // R3
        end
        if (op_class == CLS_LOGIC && func[6:5] == 2'b00 && !func[3]) begin
            AST_AND_SUBSET: assert ((result & ~opa) == '0); // R5
        end
        if (op_class == CLS_SHIFT && func[1:0] != 2'b11 && b_eff[SHAMT_W-1:0] == '0) begin
            AST_SHIFT_ZERO: assert (result == opa); // R6
        end
    end
endmodule

// File: tb/int_op_alu_bench.sv
module int_op_alu_bench;
    logic        clk;
    logic        rst_n;
    logic [63:0] opa, opb;
    logic [7:0]  lit;
    logic        use_lit;
    logic [2:0]  op_class;
    logic [6:0]  func;
    logic [63:0] result;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int_op_alu u_int_op_alu (
        .opa(opa), .opb(opb), .lit(lit), .use_lit(use_lit),
        .op_class(op_class), .func(func), .result(result)
    );

    initial clk = 0;
    always #4 clk = ~clk;

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] model(
        input logic [2:0] c, input logic [6:0] f,
        input logic [63:0] a, input logic [63:0] rb,
        input logic [7:0] l, input logic ul);
        logic [63:0] b, as, bi, r;
        logic [31:0] s32;
        int sh;
        b = ul ? {56'd0, l} : rb;
        r = 64'd0;
        case (c)
            3'd0: begin
                if (f[2:1] == 2'b11) r = 64'd0;
                else begin
                    as = (f[2:1] == 2'b01) ? a * 64'd4 :
                         (f[2:1] == 2'b10) ? a * 64'd8 : a;
                    if (f[3]) begin
                        s32 = f[0] ? (as[31:0] - b[31:0]) : (as[31:0] + b[31:0]);
                        r = sx32(s32);
                    end else r = f[0] ? as - b : as + b;
                end
            end
            3'd1: begin
                bi = f[3] ? ~b : b;
                case (f[6:5])
                    2'b00: r = a & bi;
                    2'b01: r = a | bi;
                    2'b10: r = a ^ bi;
                    default: r = 64'd0;
                endcase
            end
            3'd2: begin
                sh = int'(b[5:0]);
                case (f[1:0])
                    2'b00: r = a << sh;
                    2'b01: r = a >> sh;
                    2'b10: r = $unsigned($signed(a) >>> sh);
                    default: r = 64'd0;
                endcase
            end
            default: r = 64'd0;
        endcase
        return r;
    endfunction

    task automatic run(input logic [2:0] c, input logic [6:0] f,
                       input logic [63:0] a, input logic [63:0] rb,
                       input logic [7:0] l, input logic ul, input string req);
        logic [63:0] exp;
        @(posedge clk);
        op_class = c; func = f; opa = a; opb = rb; lit = l; use_lit = ul;
        @(negedge clk);
        exp = model(c, f, a, rb, l, ul);
        total++;
        if (result !== exp) begin
            bad++;
            $display("FAIL %s cls=%0d fn=%h a=%h b=%h lit=%h ul=%0d got=%h exp=%h",
                     req, c, f, a, rb, l, ul, result, exp);
        end
    endtask

    function automatic logic [63:0] rnd64();
        logic [63:0] v;
        int k;
        v = {$urandom(), $urandom()};
        k = $urandom_range(0, 7);
        case (k)
            0: v = 64'h0;
            1: v = 64'hFFFF_FFFF_FFFF_FFFF;
            2: v = 64'h8000_0000_0000_0000;
            3: v = 64'h0000_0000_7FFF_FFFF;
            4: v = 64'h0000_0000_8000_0000;
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        rst_n = 0; opa = 0; opb = 0; lit = 0; use_lit = 0; op_class = 3'd7; func = 0;
        repeat (2) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        total++;
        if (result !== 64'd0) begin
            bad++;
            $display("FAIL R8 reset-state class=7 got=%h exp=0", result);
        end
        // R1 literal replaces register, register bits ignored
        run(3'd0, 7'h00, 64'd10, 64'hFFFF_0000_0000_0000, 8'd255, 1'b1, "R1");
        run(3'd1, 7'h20, 64'd0, 64'hDEAD_BEEF_0000_1111, 8'h81, 1'b1, "R1");
        // R2 quad wrap
        run(3'd0, 7'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 1'b0, "R2");
        run(3'd0, 7'h01, 64'd0, 64'd1, 8'd0, 1'b0, "R2");
        // R3 long forms sign-extend
        run(3'd0, 7'h08, 64'h0000_0000_7FFF_FFFF, 64'd1, 8'd0, 1'b0, "R3");
        run(3'd0, 7'h09, 64'h1234_5678_0000_0000, 64'd0, 8'd5, 1'b1, "R3");
        run(3'd0, 7'h08, 64'hFFFF_FFFF_0000_0003, 64'h0, 8'd4, 1'b1, "R3");
        // R4 scaled and reserved scale
        run(3'd0, 7'h02, 64'd100, 64'd3, 8'd0, 1'b0, "R4");
        run(3'd0, 7'h05, 64'd100, 64'd0, 8'd1, 1'b1, "R4");
        run(3'd0, 7'h0C, 64'h2000_0000, 64'd0, 8'd0, 1'b1, "R4");
        run(3'd0, 7'h06, 64'h1234, 64'h55, 8'd0, 1'b0, "R4");
        // R5 logic codes, clear-low-bits idiom, reserved base
        run(3'd1, 7'h08, 64'hFFFF, 64'd0, 8'd3, 1'b1, "R5");
        run(3'd1, 7'h48, 64'h0F0F, 64'h00FF, 8'd0, 1'b0, "R5");
        run(3'd1, 7'h28, 64'd0, 64'd0, 8'd0, 1'b1, "R5");
        run(3'd1, 7'h60, 64'hFFFF, 64'hFFFF, 8'd0, 1'b0, "R5");
        run(3'd1, 7'h17, 64'hA5A5, 64'h0FF0, 8'd0, 1'b0, "R5");
        // R6 shift amount mod 64
        run(3'd2, 7'h00, 64'd1, 64'd64, 8'd0, 1'b0, "R6");
        run(3'd2, 7'h00, 64'd1, 64'd0, 8'd63, 1'b1, "R6");
        run(3'd2, 7'h01, 64'h8000_0000_0000_0000, 64'd0, 8'd63, 1'b1, "R6");
        // R7 arithmetic right and reserved shift
        run(3'd2, 7'h02, 64'h8000_0000_0000_0000, 64'd0, 8'd63, 1'b1, "R7");
        run(3'd2, 7'h02, 64'h4000_0000_0000_0000, 64'd0, 8'd62, 1'b1, "R7");
        run(3'd2, 7'h03, 64'hFFFF, 64'd0, 8'd1, 1'b1, "R7");
        // R8 reserved classes
        run(3'd3, 7'h00, 64'hFFFF, 64'd1, 8'd0, 1'b0, "R8");
        run(3'd6, 7'h20, 64'hFFFF, 64'd1, 8'd0, 1'b0, "R8");
        // random sweep over all classes and codes
        for (int i = 0; i < 6000; i++) begin
            logic [2:0] c;
            logic [6:0] f;
            c = 3'($urandom_range(0, 3));
            f = 7'($urandom());
            if (c == 3'd1 && ($urandom_range(0, 3) != 0))
                f = {f[6:5], 1'b0, f[3], 3'b000};
            run(c, f, rnd64(), rnd64(), 8'($urandom()), 1'($urandom()),
                c == 3'd0 ? "R2" : c == 3'd1 ? "R5" : c == 3'd2 ? "R6" : "R8");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule